// File: doc/BRIEF.md
# Serial Flash Read Sequencer (Device Side)

This block sits on the memory side of a serial NOR flash bus. It follows the interface states of a read command. It decodes the 8-bit instruction, collects address and mode bits at one or two bits per serial clock, and waits out a programmable number of latency clocks. It then streams bytes from a small internal array on one or two data lines.

The host's serial clock, chip select and data lines are brought into the system clock domain through synchronizer stages. All decisions are taken on the detected serial clock edges. Input bits are taken on rising edges. Output bits change on falling edges, so the host can sample them on the next rising edge. The block drives its data lines only while it is returning read data. The host supplies the latency code from its configuration storage as a static input.

Top module: `flash_rd_seq`

## Requirements
- R1: After reset, and while chip select is high, both output enables are 0.
- R2: While the instruction bits and the address or mode bits are being received, both output enables stay 0.
- R3: Instruction 0x03 shifts in 24 address bits on io_i[0], MSB first, and ignores the latency code. From the falling edge after the last address bit it drives bytes MSB first on io_o[1], with io_oe_o = 2'b10. Values on io_i[0] are ignored while it does so.
- R4: Instruction 0x0B takes its address as 0x03 does. It then waits 2 x lat_code_i rising edges, with io_oe_o = 0 and all input values ignored, before single-line output. A code of 0 goes straight to output.
- R5: Instruction 0x3B takes a single-line address, waits as 0x0B does, and then returns two bits per clock with io_oe_o = 2'b11. Bit 7 goes on io_o[1] and bit 6 on io_o[0] in the first clock of each byte.
- R6: Instruction 0xBB receives 24 address bits followed by 8 mode bits, two per rising edge (higher bit on io_i[1]), in 16 clocks. It enters the latency wait if 2 x lat_code_i is nonzero, otherwise dual output directly.
- R7: Any other instruction code leaves the block silent (enables 0) until chip select rises. The next selection accepts a new command.
- R8: Chip select going high forces both output enables to 0 at once, combinationally, and returns the sequencer to idle, even in the middle of a byte.
- R9: The array address is the low 8 bits of the received address. It increments after each byte and wraps from 0xFF to 0x00.
- R10: The array byte at address a is (a x 37 + 165) mod 256. io_o changes only on falling serial clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low chip select |
| io_i | input | 2 | Data lines as seen at the pins (bit 0 is the serial input) |
| lat_code_i | input | 2 | Latency code from configuration; wait = 2 x code clocks |
| io_o | output | 2 | Data driven onto the lines (bit 1 is the serial output) |
| io_oe_o | output | 2 | Per-line output enables |

## Verification
The hardest case to reach from the ports is a dual I/O read with no latency that crosses the top of the array. Here the enables must turn on at the first falling edge after the mode bits, and the address must roll over in mid-burst. The bench starts such a read at 0xFE and collects three bytes. It also lifts chip select four clocks into a byte and samples the enables one nanosecond later. This shows the release is combinational, and a read that follows straight after shows the sequencer went back to idle.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR_S,
    ST_ADDR_D,
    ST_LAT,
    ST_OUT,
    ST_DROP
  } seq_state_e;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_DOUT = 8'h3B;
  localparam logic [7:0] OP_DIO  = 8'hBB;
endpackage

// File: rtl/flash_sync.sv
module flash_sync #(
  parameter int unsigned         W       = 1,
  parameter int unsigned         STAGES  = 2,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic [W-1:0] q;
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stg[i-1].q;
      end
    end
  end

  assign q_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/flash_rom.sv
module flash_rom #(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    data_o
);
  logic [7:0] a8;
  assign a8     = 8'(addr_i);
  assign data_o = a8 * 8'd37 + 8'd165;
endmodule

// File: rtl/flash_rd_fsm.sv
module flash_rd_fsm
  import flash_rd_pkg::*;
#(
  parameter int unsigned ADDR_BITS  = 24,
  parameter int unsigned MODE_BITS  = 8,
  parameter int unsigned ARRAY_AW   = 8,
  parameter int unsigned LAT_CODE_W = 2,
  parameter int unsigned LAT_STEP   = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_act_i,
  input  logic                  sck_rise_i,
  input  logic [1:0]            io_i,
  input  logic [LAT_CODE_W-1:0] lat_code_i,
  output seq_state_e            state_o,
  output logic                  start_o,
  output logic                  dual_o,
  output logic [ARRAY_AW-1:0]   addr_o
);
  localparam int unsigned DIO_CYC  = (ADDR_BITS + MODE_BITS) / 2;
  localparam int unsigned DIO_ACYC = ADDR_BITS / 2;
  localparam int unsigned LAT_MAX  = (2**LAT_CODE_W - 1) * LAT_STEP;
  localparam int unsigned SPAN_A   = (ADDR_BITS > DIO_CYC) ? ADDR_BITS : DIO_CYC;
  localparam int unsigned SPAN     = (SPAN_A > LAT_MAX) ? SPAN_A : LAT_MAX;
  localparam int unsigned CNT_W    = $clog2(SPAN + 1);

  seq_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   lat_n;
  logic [7:0]         cmd_q;
  logic [7:0]         cmd_nxt;
  logic [ARRAY_AW-1:0] addr_q;
  logic               dual_q;
  logic               start_q;
  logic               skip_lat;

  assign lat_n    = CNT_W'(int'(lat_code_i) * LAT_STEP);
  assign cmd_nxt  = {cmd_q[6:0], io_i[0]};
  assign skip_lat = (cmd_q == OP_READ) || (lat_n == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      dual_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (!cs_act_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            state_q <= ST_CMD;
            cnt_q   <= '0;
          end
          ST_CMD: if (sck_rise_i) begin
            cmd_q <= cmd_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(7)) begin
              cnt_q <= '0;
              unique case (cmd_nxt)
                OP_READ, OP_FAST: begin state_q <= ST_ADDR_S; dual_q <= 1'b0; end
                OP_DOUT:          begin state_q <= ST_ADDR_S; dual_q <= 1'b1; end
                OP_DIO:           begin state_q <= ST_ADDR_D; dual_q <= 1'b1; end
                default:          state_q <= ST_DROP;
              endcase
            end
          end
          ST_ADDR_S: if (sck_rise_i) begin
            addr_q <= {addr_q[ARRAY_AW-2:0], io_i[0]};
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(ADDR_BITS - 1)) begin
              cnt_q   <= '0;
              start_q <= 1'b1;
              state_q <= skip_lat ? ST_OUT : ST_LAT;
            end
          end
          ST_ADDR_D: if (sck_rise_i) begin
            // mode bits follow the address and are not kept
            if (cnt_q < CNT_W'(DIO_ACYC)) addr_q <= {addr_q[ARRAY_AW-3:0], io_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DIO_CYC - 1)) begin
              cnt_q   <= '0;
              start_q <= 1'b1;
              state_q <= skip_lat ? ST_OUT : ST_LAT;
            end
          end
          ST_LAT: if (sck_rise_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == lat_n - 1'b1) begin
              cnt_q   <= '0;
              state_q <= ST_OUT;
            end
          end
          ST_OUT, ST_DROP: ;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign start_o = start_q;
  assign dual_o  = dual_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/flash_rd_shift.sv
module flash_rd_shift #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_act_i,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          run_i,
  input  logic          dual_i,
  input  logic          sck_fall_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [1:0]    io_o,
  output logic [1:0]    oe_o
);
  logic [AW-1:0] addr_q;
  logic [7:0]    sh_q;
  logic [2:0]    phase_q;
  logic [2:0]    last_phase;
  logic [1:0]    out_q;
  logic [1:0]    oe_q;

  assign last_phase = dual_i ? 3'd3 : 3'd7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      sh_q    <= '0;
      phase_q <= '0;
      out_q   <= '0;
      oe_q    <= '0;
    end else if (!cs_act_i) begin
      oe_q    <= '0;
      phase_q <= '0;
    end else begin
      if (start_i) begin
        addr_q  <= addr_i;
        phase_q <= '0;
      end
      if (run_i && sck_fall_i) begin
        oe_q    <= dual_i ? 2'b11 : 2'b10;
        phase_q <= (phase_q == last_phase) ? 3'd0 : phase_q + 3'd1;
        if (phase_q == 3'd0) begin
          out_q  <= dual_i ? rd_data_i[7:6] : {rd_data_i[7], 1'b0};
          sh_q   <= dual_i ? {rd_data_i[5:0], 2'b00} : {rd_data_i[6:0], 1'b0};
          addr_q <= addr_q + 1'b1;
        end else begin
          out_q <= dual_i ? sh_q[7:6] : {sh_q[7], 1'b0};
          sh_q  <= dual_i ? {sh_q[5:0], 2'b00} : {sh_q[6:0], 1'b0};
        end
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign io_o      = out_q;
  assign oe_o      = oe_q;
endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
  import flash_rd_pkg::*;
#(
  parameter int unsigned ADDR_BITS   = 24,
  parameter int unsigned MODE_BITS   = 8,
  parameter int unsigned ARRAY_AW    = 8,
  parameter int unsigned LAT_CODE_W  = 2,
  parameter int unsigned LAT_STEP    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sck_i,
  input  logic                  cs_ni,
  input  logic [1:0]            io_i,
  input  logic [LAT_CODE_W-1:0] lat_code_i,
  output logic [1:0]            io_o,
  output logic [1:0]            io_oe_o
);
  logic [3:0]          bus_s;
  logic                sck_q;
  logic                sck_s;
  logic                cs_act;
  logic                sck_rise;
  logic                sck_fall;
  logic [1:0]          io_s;
  seq_state_e          state;
  logic                start;
  logic                dual;
  logic [ARRAY_AW-1:0] start_addr;
  logic [ARRAY_AW-1:0] rd_addr;
  logic [7:0]          rd_data;
  logic [1:0]          oe_q;

  flash_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, io_i}),
    .q_o   (bus_s)
  );

  assign cs_act = ~bus_s[3];
  assign sck_s  = bus_s[2];
  assign io_s   = bus_s[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  flash_rd_fsm #(
    .ADDR_BITS (ADDR_BITS),
    .MODE_BITS (MODE_BITS),
    .ARRAY_AW  (ARRAY_AW),
    .LAT_CODE_W(LAT_CODE_W),
    .LAT_STEP  (LAT_STEP)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_act_i  (cs_act),
    .sck_rise_i(sck_rise),
    .io_i      (io_s),
    .lat_code_i(lat_code_i),
    .state_o   (state),
    .start_o   (start),
    .dual_o    (dual),
    .addr_o    (start_addr)
  );

  flash_rom #(.AW(ARRAY_AW)) u_rom (
    .addr_i(rd_addr),
    .data_o(rd_data)
  );

  flash_rd_shift #(.AW(ARRAY_AW)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_act_i  (cs_act),
    .start_i   (start),
    .addr_i    (start_addr),
    .run_i     (state == ST_OUT),
    .dual_i    (dual),
    .sck_fall_i(sck_fall),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .io_o      (io_o),
    .oe_o      (oe_q)
  );

  // release the lines without waiting for the synchronizer
  assign io_oe_o = oe_q & {2{~cs_ni}};
endmodule

// File: rtl/flash_rd_seq_chk.sv
module flash_rd_seq_chk
  import flash_rd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_act_i,
  input logic       sck_fall_i,
  input logic       dual_i,
  input seq_state_e state_i,
  input logic [1:0] io_o,
  input logic [1:0] io_oe_o
);
  AST_DESELECT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> state_i == ST_IDLE); // R8

  AST_OE_ONLY_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o != 2'b00 |-> state_i == ST_OUT); // R2

  AST_LAT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_LAT |-> io_oe_o == 2'b00); // R4

  AST_DUAL_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o == 2'b11 |-> dual_i); // R5

  AST_OE_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o != 2'b01); // R3

  AST_DROP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DROP && cs_act_i) |=> state_i == ST_DROP); // R7

  AST_OUT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_fall_i |=> $stable(io_o)); // R10
endmodule

bind flash_rd_seq flash_rd_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_act_i  (cs_act),
  .sck_fall_i(sck_fall),
  .dual_i    (dual),
  .state_i   (state),
  .io_o      (io_o),
  .io_oe_o   (io_oe_o)
);

// File: tb/sim_flash_rd_seq.sv
`timescale 1ns/1ps
module sim_flash_rd_seq;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic [1:0] io_drv = 2'b00;
  logic [1:0] lat_code = 2'b00;
  logic [1:0] io_o;
  logic [1:0] io_oe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0] lo_o, lo_oe, hi_o;

  always #2 clk = ~clk;

  flash_rd_seq u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .sck_i     (sck),
    .cs_ni     (cs_n),
    .io_i      (io_drv),
    .lat_code_i(lat_code),
    .io_o      (io_o),
    .io_oe_o   (io_oe_o)
  );

  function automatic logic [7:0] rom_byte(input logic [7:0] a);
    return 8'((int'(a) * 37 + 165) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one serial clock: low phase with host data, then high phase
  task automatic cyc(input logic [1:0] drv);
    sck = 1'b0;
    io_drv = drv;
    repeat (H) @(negedge clk);
    lo_o = io_o;
    lo_oe = io_oe_o;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    hi_o = io_o;
  endtask

  task automatic deselect(input string req);
    @(negedge clk);
    sck = 1'b0;
    cs_n = 1'b1;
    #1;
    chk(io_oe_o == 2'b00, req, io_oe_o, 0);
    repeat (10) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] op, input logic [23:0] addr, input logic [1:0] code,
                         input int nbytes, input int abort_cyc, input string req);
    int lat;
    bit dual;
    logic [1:0] want_oe;
    logic [31:0] dio_bits;
    logic [7:0] got, exp;
    int bad_oe, bad_stab;
    lat = (op == 8'h03) ? 0 : int'(code) * 2;
    dual = (op == 8'h3B) || (op == 8'hBB);
    want_oe = dual ? 2'b11 : 2'b10;
    lat_code = code;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    bad_oe = 0;
    for (int i = 0; i < 8; i++) begin
      cyc({1'b1, op[7-i]});
      if (lo_oe != 2'b00) bad_oe++;
    end
    if (op == 8'hBB) begin
      dio_bits = {addr, 8'hA5};
      for (int i = 0; i < 16; i++) begin
        cyc(dio_bits[31-2*i -: 2]);
        if (lo_oe != 2'b00) bad_oe++;
      end
    end else begin
      for (int i = 0; i < 24; i++) begin
        cyc({1'b0, addr[23-i]});
        if (lo_oe != 2'b00) bad_oe++;
      end
    end
    chk(bad_oe == 0, "R2 lines driven during command/address", bad_oe, 0);
    if (lat > 0) begin
      bad_oe = 0;
      for (int i = 0; i < lat; i++) begin
        cyc(i[0] ? 2'b11 : 2'b10);
        if (lo_oe != 2'b00) bad_oe++;
      end
      chk(bad_oe == 0, "R4 lines driven during latency", bad_oe, 0);
    end
    for (int b = 0; b < nbytes; b++) begin
      got = '0;
      bad_oe = 0;
      bad_stab = 0;
      for (int k = 0; k < (dual ? 4 : 8); k++) begin
        cyc(dual ? 2'b00 : {1'b0, k[0] ^ k[1]});
        if (lo_oe != want_oe) bad_oe++;
        if (hi_o != lo_o) bad_stab++;
        got = dual ? {got[5:0], lo_o} : {got[6:0], lo_o[1]};
      end
      exp = rom_byte(8'(addr[7:0] + 8'(b)));
      chk(got == exp, req, got, exp);
      chk(bad_oe == 0, {req, " enables"}, bad_oe, 0);
      chk(bad_stab == 0, "R10 output moved on rising edge", bad_stab, 0);
    end
    for (int i = 0; i < abort_cyc; i++) cyc(2'b00);
    deselect("R8 enables after chip select high");
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(io_oe_o == 2'b00, "R1 enables after reset", io_oe_o, 0);
    repeat (4) @(negedge clk);
    chk(io_oe_o == 2'b00, "R1 enables while deselected", io_oe_o, 0);
  endtask

  task automatic t_read_slow;
    do_read(8'h03, 24'h000010, 2'd3, 2, 0, "R3 slow read data");
  endtask

  task automatic t_fast;
    do_read(8'h0B, 24'h123420, 2'd2, 2, 0, "R4 fast read data code 2");
    do_read(8'h0B, 24'h000077, 2'd0, 1, 0, "R4 fast read data code 0");
  endtask

  task automatic t_dual_out;
    do_read(8'h3B, 24'h0000C3, 2'd1, 2, 0, "R5 dual output data");
  endtask

  task automatic t_dual_io;
    do_read(8'hBB, 24'hABCD31, 2'd2, 2, 0, "R6 dual I/O data with latency");
    do_read(8'hBB, 24'h0000FE, 2'd0, 3, 0, "R9 R6 wrap with no latency");
  endtask

  task automatic t_bad_op;
    int bad_oe;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) cyc({1'b0, 8'h9F >> (7-i) & 8'h01} == 2'b01 ? 2'b01 : 2'b00);
    bad_oe = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(2'(i));
      if (lo_oe != 2'b00) bad_oe++;
    end
    chk(bad_oe == 0, "R7 unknown instruction drove lines", bad_oe, 0);
    deselect("R7 enables after dropped command");
    do_read(8'h03, 24'h000050, 2'd0, 1, 0, "R7 read after dropped command");
  endtask

  task automatic t_abort;
    do_read(8'h0B, 24'h000040, 2'd1, 1, 4, "R8 read before abort");
    do_read(8'h03, 24'h000080, 2'd0, 1, 0, "R8 read after abort");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_read_slow();
    t_fast();
    t_dual_out();
    t_dual_io();
    t_bad_op();
    t_abort();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule